// File: doc/BRIEF.md
# I2C Target Protocol Engine

This block is the serial front end of a small register-backed peripheral. It watches the two-wire bus with a fast system clock. It finds bus conditions and bytes, and it answers a fixed 7-bit target address. It hands register reads and writes to a separate register bank through a simple address, strobe and data interface. SDA is open drain: the engine never drives it high, and only asserts an enable that pulls the line low for an acknowledge or for a zero read bit.

A write transaction carries a register-pointer byte followed by data bytes. Each data byte is offered to the register bank at the current pointer. The bank accepts or refuses it through a per-write flag, and the engine acknowledges or refuses the byte to match. A read returns bytes from the pointer and steps it after each byte. The pointer persists between transactions, so a read with no pointer write continues from where the last access left off. While the bank's non-volatile commit logic reports busy, the engine ignores its own address, which lets a host poll for completion.

Top module: `i2c_target_engine`

## Requirements
- R1: A START (SDA falling while SCL is high) restarts address reception from any state, including in the middle of a transaction as a repeated START. A STOP (SDA rising while SCL is high) returns the engine to idle, and bytes clocked after a STOP without a new START are not acknowledged. The SDA enable never changes while the synchronised SCL is high.
- R2: Only the address bytes 50h (write) and 51h (read) are acknowledged. Bit 0 of the address byte selects read (1) or write (0). Any other address byte is refused, and the engine ignores the bus until the next START.
- R3: An acknowledge holds SDA low for the whole ninth SCL clock of a byte. The engine releases SDA after the SCL falling edge that ends that clock.
- R4: The register-pointer byte is acknowledged and loaded only for values 00h to 06h and 08h. The value 07h and any value above 08h are refused and leave the pointer unchanged.
- R5: Each data byte of a write is presented at the current pointer with a single-cycle write strobe. When the bank accepts it, the byte is acknowledged and the pointer advances by one.
- R6: Read data is sent MSB first. The pointer advances after every byte sent, and from 08h it wraps to 00h.
- R7: A read that starts directly with 51h returns the register at the current pointer, which is the address after the last one accessed.
- R8: A data byte refused by the bank is answered with NACK and does not advance the pointer. The engine then ignores the bus until the next START.
- R9: When the controller answers a read byte with NACK, the engine stops driving SDA and sends nothing further until a new START.
- R10: While the busy input is high, the engine does not acknowledge its own address in either direction.
- R11: After reset the SDA enable is low and the pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| sdaOe | output | 1 | Open-drain enable: 1 pulls SDA low |
| regAddr | output | 8 | Register pointer presented to the register bank |
| regWe | output | 1 | Single-cycle write strobe |
| regWdata | output | 8 | Byte to be written at regAddr |
| regRdata | input | 8 | Register bank contents at regAddr |
| regWrOk | input | 1 | Bank accepts the write offered this cycle |
| nvBusy | input | 1 | Non-volatile commit in progress |

## Verification
The hardest state to reach from the ports is the pointer after a refused access. Neither a refused pointer byte nor a refused data byte produces any output of its own. The bench therefore follows each refusal with a read that carries no pointer write, so the byte returned shows which register the pointer still selects. The wrap from 08h through the reserved 07h slot is reached by a four-byte sequential read that starts at 06h. All 256 address bytes and every pointer value up to 10h are swept, with expected ACKs computed in the bench.

// File: rtl/i2ct_pkg.sv
`timescale 1ns/1ps
package i2ct_pkg;

  localparam int DATA_W = 8;

  // bus events decoded from the synchronised lines
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sdaLvl;
  } busEv_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadTx;
    logic shiftTx;
    logic ptrLoad;
    logic ptrInc;
  } dpCtl_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_PTR,
    S_WDATA,
    S_RDATA,
    S_WAIT
  } engState_t;

endpackage

// File: rtl/i2ct_datapath.sv
`timescale 1ns/1ps
module i2ct_datapath
  import i2ct_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  LAST_REG    = 8'h08
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] regRdata,
  output busEv_t            ev,
  output logic              sclLvl,
  output logic [DATA_W-1:0] shiftReg,
  output logic [DATA_W-1:0] ptr
);

  logic [SYNC_STAGES-1:0] sclSy, sdaSy;
  logic sclD, sdaD;
  logic sclNow, sdaNow;

  // idle bus is high, so synchronisers reset high to avoid false edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSy <= '1;
      sdaSy <= '1;
      sclD  <= 1'b1;
      sdaD  <= 1'b1;
    end else begin
      sclSy <= {sclSy[SYNC_STAGES-2:0], sclIn};
      sdaSy <= {sdaSy[SYNC_STAGES-2:0], sdaIn};
      sclD  <= sclNow;
      sdaD  <= sdaNow;
    end
  end

  assign sclNow = sclSy[SYNC_STAGES-1];
  assign sdaNow = sdaSy[SYNC_STAGES-1];
  assign sclLvl = sclNow;

  always_comb begin
    ev.sclRise   = sclNow & ~sclD;
    ev.sclFall   = ~sclNow & sclD;
    ev.startSeen = sclNow & sclD & sdaD & ~sdaNow;
    ev.stopSeen  = sclNow & sclD & ~sdaD & sdaNow;
    ev.sdaLvl    = sdaNow;
  end

  // one shift register serves both directions
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (ctl.loadTx) begin
      shiftReg <= regRdata;
    end else if (ctl.shiftTx) begin
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b1};
    end else if (ctl.shiftIn) begin
      shiftReg <= {shiftReg[DATA_W-2:0], sdaNow};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (ctl.ptrLoad) begin
      ptr <= shiftReg;
    end else if (ctl.ptrInc) begin
      ptr <= (ptr == LAST_REG) ? '0 : ptr + 1'b1;
    end
  end

endmodule

// File: rtl/i2ct_control.sv
`timescale 1ns/1ps
module i2ct_control
  import i2ct_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h28,
  parameter logic [7:0] LAST_REG    = 8'h08,
  parameter logic [7:0] RSVD_REG    = 8'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEv_t            ev,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txMsb,
  input  logic              regWrOk,
  input  logic              nvBusy,
  output dpCtl_t            ctl,
  output logic              regWe,
  output logic              sdaOe
);

  localparam logic [3:0] BIT_LAST = 4'(DATA_W);
  localparam logic [3:0] BIT_ACK  = BIT_LAST + 4'd1;

  engState_t st, stN;
  logic [3:0] bitCnt, cntN;
  logic rwReg, rwN, oeN, ackOk, ptrOk;

  assign ptrOk = (rxByte <= LAST_REG) && (rxByte != RSVD_REG);

  always_comb begin
    stN   = st;
    cntN  = bitCnt;
    rwN   = rwReg;
    oeN   = sdaOe;
    ctl   = '0;
    regWe = 1'b0;
    ackOk = 1'b0;
    if (ev.startSeen) begin
      stN  = S_ADDR;
      cntN = '0;
      oeN  = 1'b0;
    end else if (ev.stopSeen) begin
      stN  = S_IDLE;
      cntN = '0;
      oeN  = 1'b0;
    end else begin
      case (st)
        S_ADDR, S_PTR, S_WDATA: begin
          if (ev.sclRise && bitCnt < BIT_LAST) begin
            ctl.shiftIn = 1'b1;
            cntN        = bitCnt + 4'd1;
          end else if (ev.sclFall && bitCnt == BIT_LAST) begin
            // byte complete: decide the answer while SCL is low
            case (st)
              S_ADDR: begin
                ackOk = (rxByte[7:1] == TARGET_ADDR) && !nvBusy;
                rwN   = rxByte[0];
              end
              S_PTR: begin
                ackOk       = ptrOk;
                ctl.ptrLoad = ptrOk;
              end
              default: begin
                regWe      = 1'b1;
                ackOk      = regWrOk;
                ctl.ptrInc = regWrOk;
              end
            endcase
            if (ackOk) begin
              oeN  = 1'b1;
              cntN = BIT_ACK;
            end else begin
              stN  = S_WAIT;
              cntN = '0;
            end
          end else if (ev.sclFall && bitCnt == BIT_ACK) begin
            oeN  = 1'b0;
            cntN = '0;
            case (st)
              S_ADDR: begin
                if (rwReg) begin
                  stN        = S_RDATA;
                  ctl.loadTx = 1'b1;
                  oeN        = ~txMsb;
                end else begin
                  stN = S_PTR;
                end
              end
              default: stN = S_WDATA;
            endcase
          end
        end
        S_RDATA: begin
          if (ev.sclRise && bitCnt < BIT_LAST) begin
            cntN = bitCnt + 4'd1;
          end else if (ev.sclRise && bitCnt == BIT_LAST) begin
            // controller answer on the ninth clock
            ctl.ptrInc = 1'b1;
            cntN       = BIT_ACK;
            if (ev.sdaLvl) begin
              stN  = S_WAIT;
              cntN = '0;
            end
          end else if (ev.sclFall) begin
            if (bitCnt == BIT_ACK) begin
              ctl.loadTx = 1'b1;
              oeN        = ~txMsb;
              cntN       = '0;
            end else if (bitCnt == BIT_LAST) begin
              oeN = 1'b0;
            end else if (bitCnt != '0) begin
              ctl.shiftTx = 1'b1;
              oeN         = ~rxByte[DATA_W-2];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= S_IDLE;
      bitCnt <= '0;
      rwReg  <= 1'b0;
      sdaOe  <= 1'b0;
    end else begin
      st     <= stN;
      bitCnt <= cntN;
      rwReg  <= rwN;
      sdaOe  <= oeN;
    end
  end

endmodule

// File: rtl/i2c_target_engine.sv
`timescale 1ns/1ps
module i2c_target_engine
  import i2ct_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h28,
  parameter logic [7:0] LAST_REG    = 8'h08,
  parameter logic [7:0] RSVD_REG    = 8'h07,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  output logic [7:0] regAddr,
  output logic       regWe,
  output logic [7:0] regWdata,
  input  logic [7:0] regRdata,
  input  logic       regWrOk,
  input  logic       nvBusy
);

  busEv_t busEv;
  dpCtl_t dpCtl;
  logic [DATA_W-1:0] shiftReg;
  logic sclLvl;

  i2ct_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .LAST_REG   (LAST_REG)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .ctl     (dpCtl),
    .regRdata(regRdata),
    .ev      (busEv),
    .sclLvl  (sclLvl),
    .shiftReg(shiftReg),
    .ptr     (regAddr)
  );

  i2ct_control #(
    .TARGET_ADDR(TARGET_ADDR),
    .LAST_REG   (LAST_REG),
    .RSVD_REG   (RSVD_REG)
  ) u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .ev     (busEv),
    .rxByte (shiftReg),
    .txMsb  (regRdata[DATA_W-1]),
    .regWrOk(regWrOk),
    .nvBusy (nvBusy),
    .ctl    (dpCtl),
    .regWe  (regWe),
    .sdaOe  (sdaOe)
  );

  assign regWdata = shiftReg;

endmodule

// File: rtl/i2ct_checker.sv
`timescale 1ns/1ps
module i2ct_checker #(
  parameter logic [7:0] LAST_REG = 8'h08
) (
  input logic       clk,
  input logic       rstN,
  input logic       sclLvl,
  input logic       sdaOe,
  input logic       regWe,
  input logic [7:0] regAddr
);

  // R1: the SDA enable holds while SCL stays high
  p_sda_stable_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sclLvl && $past(sclLvl)) |-> $stable(sdaOe));

  // R3: the enable only moves in a cycle where SCL was seen low
  p_oe_scl_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !$past(sclLvl));

  // R5: write strobe is a single pulse
  p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  // R5: writes are offered while SCL is low
  p_we_scl_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> !sclLvl);

  // R6: the pointer never leaves the register range
  p_ptr_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    regAddr <= LAST_REG);

endmodule

bind i2c_target_engine i2ct_checker #(.LAST_REG(LAST_REG)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .sclLvl (sclLvl),
  .sdaOe  (sdaOe),
  .regWe  (regWe),
  .regAddr(regAddr)
);

// File: tb/test_i2c_target_engine.sv
`timescale 1ns/1ps
module test_i2c_target_engine;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic nvBusy = 1'b0;
  logic sdaOe, regWe, regWrOk;
  logic [7:0] regAddr, regWdata, regRdata;
  logic busSda;
  logic [7:0] mem [0:8];
  logic [7:0] expMem [0:8];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign busSda = sdaM & ~sdaOe;

  i2c_target_engine i_i2c_target_engine (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclM),
    .sdaIn   (busSda),
    .sdaOe   (sdaOe),
    .regAddr (regAddr),
    .regWe   (regWe),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .regWrOk (regWrOk),
    .nvBusy  (nvBusy)
  );

  // register bank model: 01h and 07h refuse writes, 07h reads as FFh
  assign regRdata = (regAddr == 8'h07) ? 8'hFF :
                    (regAddr <= 8'h08) ? mem[regAddr[3:0]] : 8'h00;
  assign regWrOk  = (regAddr != 8'h01) && (regAddr != 8'h07) && (regAddr <= 8'h08);

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 9; i++) mem[i] <= 8'(i * 16 + 3);
    end else if (regWe && regWrOk) begin
      mem[regAddr[3:0]] <= regWdata;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic hold();
    repeat (5) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; hold();
    sclM = 1'b1; hold();
    sdaM = 1'b0; hold();
    sclM = 1'b0; hold();
  endtask

  task automatic stopCond();
    sclM = 1'b0; sdaM = 1'b0; hold();
    sclM = 1'b1; hold();
    sdaM = 1'b1; hold();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; hold();
      sclM = 1'b1; hold();
      sclM = 1'b0;
    end
    sdaM = 1'b1; hold();
    sclM = 1'b1; hold();
    acked = (busSda == 1'b0);
    sclM = 1'b0;
  endtask

  task automatic recvByte(input logic mAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold();
      sclM = 1'b1; hold();
      b[i] = busSda;
      sclM = 1'b0;
    end
    sdaM = ~mAck; hold();
    sclM = 1'b1; hold();
    sclM = 1'b0;
    sdaM = 1'b1;
  endtask

  task automatic setPtr(input logic [7:0] p, output logic acked);
    logic a;
    startCond();
    sendByte(8'h50, a);
    sendByte(p, acked);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 9; i++) expMem[i] = 8'(i * 16 + 3);
    hold();

    // R11: reset state
    check(sdaOe == 1'b0, "R11 enable after reset", {7'd0, sdaOe}, 8'h00);
    startCond();
    sendByte(8'h51, a);
    check(a, "R11 read address ack", {7'd0, a}, 8'h01);
    recvByte(1'b0, d);
    check(d == expMem[0], "R11 R7 read from reset pointer", d, expMem[0]);
    stopCond();

    // R2: sweep all address bytes
    for (int ab = 0; ab < 256; ab++) begin
      logic expAck;
      expAck = (ab == 8'h50) || (ab == 8'h51);
      startCond();
      sendByte(8'(ab), a);
      check(a == expAck, "R2 address sweep", 8'(ab), {7'd0, expAck});
      if (a && ab == 8'h51) recvByte(1'b0, d);
      if (ab == 8'h52) begin
        sendByte(8'h50, a);
        check(!a, "R2 ignored after refused address", {7'd0, a}, 8'h00);
      end
      stopCond();
    end

    // R4: pointer sweep
    for (int i = 0; i < 18; i++) begin
      logic [7:0] p;
      logic expAck;
      p = (i == 17) ? 8'hFF : 8'(i);
      expAck = (p <= 8'h08) && (p != 8'h07);
      setPtr(p, a);
      check(a == expAck, "R4 pointer sweep", p, {7'd0, expAck});
      stopCond();
    end
    // last accepted pointer was 08h; refused ones left it there; R6 wrap
    startCond();
    sendByte(8'h51, a);
    recvByte(1'b1, d);
    check(d == expMem[8], "R4 pointer kept after refusal", d, expMem[8]);
    recvByte(1'b0, d);
    check(d == expMem[0], "R6 wrap 08h to 00h", d, expMem[0]);
    stopCond();

    // R5: multi-byte write from 02h
    setPtr(8'h02, a);
    hold();
    check(sdaOe == 1'b0, "R3 release after ack", {7'd0, sdaOe}, 8'h00);
    for (int i = 0; i < 3; i++) begin
      d = 8'(8'h11 * (i + 1));
      sendByte(d, a);
      check(a, "R5 data ack", {7'd0, a}, 8'h01);
      expMem[2 + i] = d;
    end
    stopCond();
    // R1 repeated start into read, R6 ordering
    setPtr(8'h02, a);
    startCond();
    sendByte(8'h51, a);
    check(a, "R1 repeated start read ack", {7'd0, a}, 8'h01);
    for (int i = 0; i < 3; i++) begin
      recvByte(i != 2, d);
      check(d == expMem[2 + i], "R5 R6 readback", d, expMem[2 + i]);
    end
    stopCond();

    // R7: read with no pointer continues at 05h
    startCond();
    sendByte(8'h51, a);
    recvByte(1'b0, d);
    check(d == expMem[5], "R7 continue after last access", d, expMem[5]);
    stopCond();

    // R6: across reserved slot and wrap
    setPtr(8'h06, a);
    startCond();
    sendByte(8'h51, a);
    recvByte(1'b1, d);
    check(d == expMem[6], "R6 seq 06h", d, expMem[6]);
    recvByte(1'b1, d);
    check(d == 8'hFF, "R6 seq 07h", d, 8'hFF);
    recvByte(1'b1, d);
    check(d == expMem[8], "R6 seq 08h", d, expMem[8]);
    recvByte(1'b0, d);
    check(d == expMem[0], "R6 seq wrap 00h", d, expMem[0]);
    stopCond();

    // R8: refused write
    setPtr(8'h01, a);
    sendByte(8'hAA, a);
    check(!a, "R8 refused write nack", {7'd0, a}, 8'h00);
    sendByte(8'h55, a);
    check(!a, "R8 ignored after refusal", {7'd0, a}, 8'h00);
    stopCond();
    startCond();
    sendByte(8'h51, a);
    recvByte(1'b0, d);
    check(d == expMem[1], "R8 pointer not advanced", d, expMem[1]);
    stopCond();

    // R9: controller NACK ends the read
    setPtr(8'h04, a);
    startCond();
    sendByte(8'h51, a);
    recvByte(1'b0, d);
    check(d == expMem[4], "R9 last byte", d, expMem[4]);
    recvByte(1'b0, d);
    check(d == 8'hFF, "R9 silent after nack", d, 8'hFF);
    stopCond();

    // R10: busy hides the address
    nvBusy = 1'b1;
    startCond();
    sendByte(8'h50, a);
    check(!a, "R10 busy write address", {7'd0, a}, 8'h00);
    stopCond();
    startCond();
    sendByte(8'h51, a);
    check(!a, "R10 busy read address", {7'd0, a}, 8'h00);
    stopCond();
    nvBusy = 1'b0;
    startCond();
    sendByte(8'h50, a);
    check(a, "R10 ack once idle", {7'd0, a}, 8'h01);
    stopCond();

    // R1: STOP ends the transaction
    setPtr(8'h03, a);
    stopCond();
    sendByte(8'h44, a);
    check(!a, "R1 byte after stop ignored", {7'd0, a}, 8'h00);
    stopCond();
    setPtr(8'h03, a);
    startCond();
    sendByte(8'h51, a);
    recvByte(1'b0, d);
    check(d == expMem[3], "R1 register unchanged after stop", d, expMem[3]);
    stopCond();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule